// File: doc/BRIEF.md
# Per-CPU Interrupt Level Combiner

This block sits beside one processor and merges every interrupt source aimed at it into the fifteen interrupt-level lines the processor samples. It keeps a 32-bit pending word with three kinds of stored source. Fifteen software request bits can be set and cleared through a small register port. A level-15 flag is set by the rising edge of a broadcast input. A timer flag copies the per-CPU timer line. The hard interrupt levels that the system controller has routed to this CPU are also merged in, but they are not stored. They show in the pending word and on the lines only while the routed vector carries them.

Software request bits sit in the upper half of the pending word and are shifted down onto levels. The timer and level-15 sources skip per-source masking. Only the global disable input holds them off the lines. The level lines are registered. They change one clock edge after the input or write that caused the change, and they do not glitch between edges.

Top module: `irl_combiner`

## Requirements
- R1: While reset is low, all stored pending bits and all level lines are 0.
- R2: A read at byte offset 0x0 returns this word. Bits 31:17 hold software request bits for levels 15..1, where bit n+16 is level n. Bit 16 is 0. Bit 15 is the level-15 flag ORed with routed level 15. Bit 14 is the timer flag ORed with routed level 14. Bits 13:1 are routed levels 13..1. Bit 0 is 0.
- R3: A write to offset 0x4 clears each software bit (31:17) and the level-15 flag (bit 15) whose data bit is 1. It leaves the timer flag untouched.
- R4: A write to offset 0x8 sets each software bit (31:17) whose data bit is 1. Data bits 16:0 are ignored.
- R5: The timer flag takes the value of the timer input at every clock edge.
- R6: The level-15 flag is set on a rising edge of the broadcast input and cleared on its falling edge. A rising edge wins over a software clear in the same cycle.
- R7: At each clock edge, level line n is loaded with the OR of three terms: software bit n, routed level n, and (for n = 15 or 14, with global disable low) the level-15 flag or the timer flag. The terms use the values taken at that same edge.
- R8: While global disable is high, the timer and level-15 flags do not reach lines 14 and 15. Software bits and routed levels still do.
- R9: A read at any offset other than 0x0 returns 0. A write to any offset other than 0x4 or 0x8 changes no state.
- R10: Routed levels are not stored. Once the routed vector drops a level, that level leaves the read word at once and leaves the lines at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| hard_lvl | input | 15 | Routed hard levels, bit n = level n (n = 1..15) |
| glob_dis | input | 1 | Global disable for the timer and level-15 sources |
| lvl15_in | input | 1 | Level-15 broadcast input |
| timer_in | input | 1 | Per-CPU timer line |
| irl_o | output | 15 | Registered level lines, bit n = level n |

## Verification
The bench builds the block with its default 4-bit byte address. The whole offset space is therefore 16 values, and random accesses often land on the three decoded offsets, on the unused word at 0xC and on misaligned offsets. Random stimulus also toggles the broadcast, timer, disable and routed vector together. This exercises edge cases such as a rising level-15 edge during a clear, and a timer bit that lines up with a routed level 14.

// File: rtl/irl_combiner.sv
module irl_combiner #(
  parameter int ADDR_W   = 4,
  parameter int OFS_PEND = 0,
  parameter int OFS_CLR  = 4,
  parameter int OFS_SET  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [15:1]       hard_lvl,
  input  logic              glob_dis,
  input  logic              lvl15_in,
  input  logic              timer_in,
  output logic [15:1]       irl_o
);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(OFS_PEND);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_CLR);
  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(OFS_SET);

  logic [15:1] sw_q, sw_d, lvl_d;
  logic        l15_q, l15_d, l15_prev, tmr_q;

  wire wr_clr   = reg_we && (reg_addr == A_CLR);
  wire wr_set   = reg_we && (reg_addr == A_SET);
  wire l15_rise = lvl15_in && !l15_prev;
  wire l15_fall = !lvl15_in && l15_prev;
  wire unused_wdata = ^{reg_wdata[16], reg_wdata[14:0]};

  assign sw_d  = (sw_q & ~(wr_clr ? reg_wdata[31:17] : 15'd0))
               | (wr_set ? reg_wdata[31:17] : 15'd0);
  assign l15_d = l15_rise | (l15_q & !l15_fall & !(wr_clr && reg_wdata[15]));
  assign lvl_d = sw_d | hard_lvl
               | ({l15_d, timer_in, 13'd0} & {15{!glob_dis}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q     <= '0;
      l15_q    <= 1'b0;
      l15_prev <= 1'b0;
      tmr_q    <= 1'b0;
      irl_o    <= '0;
    end else begin
      sw_q     <= sw_d;
      l15_q    <= l15_d;
      l15_prev <= lvl15_in;
      tmr_q    <= timer_in;
      irl_o    <= lvl_d;
    end
  end

  assign reg_rdata = (reg_addr == A_PEND)
    ? {sw_q, 1'b0, l15_q | hard_lvl[15], tmr_q | hard_lvl[14], hard_lvl[13:1], 1'b0}
    : 32'd0;
endmodule

// File: rtl/irl_combiner_chk.sv
module irl_combiner_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [15:1]       hard_lvl,
  input logic              glob_dis,
  input logic              timer_in,
  input logic [15:1]       irl_o,
  input logic [15:1]       sw_q
);
  localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(8);

  a_r3_clear_sw: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_CLR && reg_wdata[17]) |=> !sw_q[1]);

  a_r4_set_sw: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_SET && reg_wdata[31]) |=> sw_q[15]);

  a_r5_timer_line: assert property (@(posedge clk) disable iff (!rst_n)
    (!glob_dis && timer_in) |=> irl_o[14]);

  a_r8_disable_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (glob_dis && !hard_lvl[14] && !sw_q[14] &&
     !(reg_we && reg_addr == A_SET && reg_wdata[30])) |=> !irl_o[14]);

  a_r9_unused_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr != A_CLR && reg_addr != A_SET) |=> $stable(sw_q));

  a_r7_sw_line: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_SET && reg_wdata[19]) |=> irl_o[3]);
endmodule

bind irl_combiner irl_combiner_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/irl_combiner_test.sv
`timescale 1ns/1ps
module irl_combiner_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:1] hard_lvl = '0;
  logic        glob_dis = 1'b0;
  logic        lvl15_in = 1'b0;
  logic        timer_in = 1'b0;
  logic [15:1] irl_o;

  int n_cmp = 0, n_bad = 0;
  logic [15:1] m_sw = '0, m_irl = '0;
  logic m_l15 = 1'b0, m_tmr = 1'b0, m_prev = 1'b0;

  always #2.5 clk = ~clk;

  irl_combiner uut (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hard_lvl(hard_lvl),
    .glob_dis(glob_dis), .lvl15_in(lvl15_in), .timer_in(timer_in), .irl_o(irl_o));

  function automatic logic [31:0] exp_rd(logic [3:0] a);
    if (a != 4'h0) return 32'd0;
    return {m_sw, 1'b0, m_l15 | hard_lvl[15], m_tmr | hard_lvl[14], hard_lvl[13:1], 1'b0};
  endfunction

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic chk(string tag);
    logic [31:0] er;
    er = exp_rd(reg_addr);
    n_cmp++;
    if (irl_o !== m_irl) begin
      n_bad++;
      $display("FAIL %s irl_o actual=%h expected=%h", tag, irl_o, m_irl);
    end
    n_cmp++;
    if (reg_rdata !== er) begin
      n_bad++;
      $display("FAIL %s reg_rdata@%h actual=%h expected=%h", tag, reg_addr, reg_rdata, er);
    end
  endtask

  task automatic drive(logic we, logic [3:0] a, logic [31:0] d, logic [15:1] h,
                       logic gd, logic l15, logic tm);
    reg_we = we; reg_addr = a; reg_wdata = d; hard_lvl = h;
    glob_dis = gd; lvl15_in = l15; timer_in = tm;
  endtask

  task automatic step(string tag);
    logic [15:1] nsw;
    logic rise, fall, clr;
    @(posedge clk);
    nsw = m_sw;
    clr = reg_we && reg_addr == 4'h4;
    if (clr) nsw &= ~reg_wdata[31:17];
    if (reg_we && reg_addr == 4'h8) nsw |= reg_wdata[31:17];
    rise = lvl15_in && !m_prev;
    fall = !lvl15_in && m_prev;
    m_l15 = rise ? 1'b1 : (fall ? 1'b0 : ((clr && reg_wdata[15]) ? 1'b0 : m_l15));
    m_prev = lvl15_in;
    m_tmr = timer_in;
    m_sw = nsw;
    m_irl = nsw | hard_lvl | (glob_dis ? 15'd0 : {m_l15, m_tmr, 13'd0});
    @(negedge clk);
    chk(tag);
  endtask

  initial begin
    #(5.0 * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk("R1");
    rst_n = 1'b1;

    drive(1, 4'h8, 32'hFFFF_FFFF, '0, 0, 0, 0); step("R4");
    drive(0, 4'h0, 32'h0, '0, 0, 0, 0); step("R4");
    drive(0, 4'h0, 32'h0, '0, 0, 0, 1); step("R5");
    drive(1, 4'h4, 32'hAAAA_FFFF, '0, 0, 0, 1); step("R3");
    drive(0, 4'h0, 32'h0, '0, 0, 0, 1); step("R3");
    drive(0, 4'h0, 32'h0, '0, 0, 0, 0); step("R5");
    drive(0, 4'h0, 32'h0, '0, 0, 1, 0); step("R6");
    drive(1, 4'h4, 32'h0000_8000, '0, 0, 1, 0); step("R6");
    drive(0, 4'h0, 32'h0, '0, 0, 1, 0); step("R6");
    drive(0, 4'h0, 32'h0, '0, 0, 0, 0); step("R6");
    drive(1, 4'h4, 32'hFFFF_FFFF, '0, 0, 1, 0); step("R6");
    drive(0, 4'h0, 32'h0, '0, 0, 1, 1); step("R7");
    drive(0, 4'h0, 32'h0, 15'h0005, 1, 1, 1); step("R8");
    drive(1, 4'h8, 32'h0002_0000, 15'h0005, 1, 1, 1); step("R8");
    drive(0, 4'h0, 32'h0, 15'h4000, 1, 1, 1); step("R8");
    drive(0, 4'h0, 32'h0, 15'h7FFF, 0, 1, 0); step("R2");
    drive(0, 4'h0, 32'h0, '0, 0, 1, 0); step("R10");
    drive(1, 4'hC, 32'hFFFF_FFFF, '0, 0, 1, 0); step("R9");
    drive(1, 4'h0, 32'hFFFF_FFFF, '0, 0, 1, 0); step("R9");
    drive(0, 4'h4, 32'h0, '0, 0, 1, 0); step("R9");
    drive(0, 4'h0, 32'h0, '0, 0, 1, 0); step("R9");

    for (int i = 0; i < 4000; i++) begin
      logic [3:0] a;
      case ($urandom_range(0, 3))
        0: a = 4'h4;
        1: a = 4'h8;
        2: a = 4'h0;
        default: a = 4'($urandom_range(0, 15));
      endcase
      drive(1'($urandom_range(0, 1)), a, $urandom(),
            ($urandom_range(0, 2) == 0) ? 15'($urandom()) : 15'd0,
            ($urandom_range(0, 3) == 0), 1'($urandom_range(0, 1)),
            1'($urandom_range(0, 1)));
      step("R7");
    end
    finish_run();
  end
endmodule